// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with One-Shot Alarm

This peripheral keeps a free-running binary count of seconds behind a small byte-wide register bus. Software starts or stops counting through a run bit and sets the time through staged write bytes. Only the final write to the lowest byte commits all bytes to the counter at once. The live count can be read back a byte at a time. Software can detect a carry that happens during such a read by reading the lowest byte a second time and comparing the two values.

A compare register of the same width can be armed. When the count equals it while the alarm is armed, a level interrupt rises and stays high until software acknowledges it. The hardware disarms the alarm when it fires, so one arming gives one interrupt. Each second is marked by a one-cycle tick pulse from outside the block. The bus uses single-cycle write and read strobes, and read data appears one cycle after the read strobe.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register offset reads 0x00, the interrupt is low, the counter is stopped and the alarm is disarmed.
- R2: While bit 7 of the control register (offset 0) is 1, each tick pulse adds one to the counter. While that bit is 0, ticks leave the counter unchanged.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick.
- R4: Writes to time-write bytes 1..3 (offsets 3..5) only stage data and read back from those offsets. A write to byte 0 (offset 2) loads the counter with the staged upper bytes and the written low byte in the same edge.
- R5: If a byte-0 time write and a tick fall in the same cycle, the load wins and the tick is dropped.
- R6: Offsets 6..9 return live counter bytes, least significant first. A tick between a read of offset 6 and a second read of offset 6 can show a smaller second value, and software uses this to detect a carry.
- R7: Offsets 10..13 hold the alarm compare value, least significant byte first, and read back what was written.
- R8: With alarm enable bit 1 of offset 1 set, the interrupt rises one cycle after the counter equals the alarm value. With that bit clear, no interrupt is raised.
- R9: The interrupt stays high until a write with bit 0 set reaches the acknowledge register (offset 14). Writing 0 has no effect, and the offset always reads 0x00.
- R10: When the alarm fires, the alarm enable bit clears itself. A later match without re-arming raises no interrupt.
- R11: Read data is registered one cycle after the read strobe, and an unmapped offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The in-line properties check on every cycle that the count stays put while stopped, steps by one and wraps on a tick, and takes the staged value on a commit. They also check that a match with the alarm armed raises the interrupt, that the interrupt never rises without an armed match, that it holds until acknowledged, and that the enable clears after a fire. Other behaviour shows only in the bench's scenarios. These include the staged bytes not reaching the counter early and a load beating a simultaneous tick. They also include the visible carry between two low-byte reads, the one-shot behaviour when the count later matches again, and the read-back values at each offset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   // Control-register bit positions (decoded by software drivers)
   localparam int RUN_BIT = 7;
   localparam int AEN_BIT = 1;
   localparam int ACK_BIT = 0;

   localparam int OFS_CTRL  = 0;
   localparam int OFS_ACTRL = 1;

   // Region bases derived from the number of time bytes
   function automatic int wr_base(input int nbytes);
      return 2;
   endfunction
   function automatic int rd_base(input int nbytes);
      return 2 + nbytes;
   endfunction
   function automatic int al_base(input int nbytes);
      return 2 + 2 * nbytes;
   endfunction
   function automatic int ack_ofs(input int nbytes);
      return 2 + 3 * nbytes;
   endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   output logic [TIME_W-1:0] cnt
);
   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   generate
      if (TIME_W < 2) begin : g_bad_width
         $error("rtc_counter: TIME_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (run && tick)
         cnt <= cnt + ONE;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(run && tick)) |=> $stable(cnt));
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && run && tick && cnt != '1) |=> (cnt == $past(cnt) + ONE));
   assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && run && tick && cnt == '1) |=> (cnt == '0));
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] cnt,
   input  logic [TIME_W-1:0] alarm_val,
   input  logic              armed,
   input  logic              ack,
   output logic              fire,
   output logic              irq
);
   logic pending;

   assign fire = armed && (cnt == alarm_val);
   assign irq  = pending;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pending <= 1'b0;
      else if (fire)
         pending <= 1'b1;
      else if (ack)
         pending <= 1'b0;
   end

   assert_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cnt == alarm_val) |=> irq);
   assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(armed && cnt == alarm_val));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int NBYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     rd,
   output logic [DATA_W-1:0]        rdata,
   input  logic [NBYTES*DATA_W-1:0] cnt,
   input  logic                     fire,
   output logic                     run,
   output logic                     armed,
   output logic [NBYTES*DATA_W-1:0] alarm_val,
   output logic                     load,
   output logic [NBYTES*DATA_W-1:0] load_val,
   output logic                     ack
);
   localparam int WR_B  = wr_base(NBYTES);
   localparam int RD_B  = rd_base(NBYTES);
   localparam int AL_B  = al_base(NBYTES);
   localparam int ACK_O = ack_ofs(NBYTES);

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("rtc_regfile: DATA_W must be at least 8");
      end
      if (NBYTES < 2) begin : g_bad_bytes
         $error("rtc_regfile: NBYTES must be at least 2");
      end
      if (ACK_O >= (1 << ADDR_W)) begin : g_bad_addr
         $error("rtc_regfile: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [DATA_W-1:0] stage [NBYTES];
   logic [DATA_W-1:0] alarm_b [NBYTES];
   logic [DATA_W-1:0] rd_mux;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // Byte lanes: staging and alarm storage
   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n)
               stage[k] <= '0;
            else if (wr && hit(addr, WR_B + k))
               stage[k] <= wdata;
         end
         always_ff @(posedge clk) begin
            if (!rst_n)
               alarm_b[k] <= '0;
            else if (wr && hit(addr, AL_B + k))
               alarm_b[k] <= wdata;
         end
         assign alarm_val[k*DATA_W +: DATA_W] = alarm_b[k];
         if (k == 0) begin : g_low
            assign load_val[DATA_W-1:0] = wdata;
         end else begin : g_up
            assign load_val[k*DATA_W +: DATA_W] = stage[k];
         end
      end
   endgenerate

   assign load = wr && hit(addr, WR_B);
   assign ack  = wr && hit(addr, ACK_O) && wdata[ACK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)
         run <= 1'b0;
      else if (wr && hit(addr, OFS_CTRL))
         run <= wdata[RUN_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (fire)
         armed <= 1'b0;
      else if (wr && hit(addr, OFS_ACTRL))
         armed <= wdata[AEN_BIT];
   end

   always_comb begin
      rd_mux = '0;
      if (hit(addr, OFS_CTRL))
         rd_mux[RUN_BIT] = run;
      if (hit(addr, OFS_ACTRL))
         rd_mux[AEN_BIT] = armed;
      for (int i = 0; i < NBYTES; i++) begin
         if (hit(addr, WR_B + i))
            rd_mux = stage[i];
         if (hit(addr, RD_B + i))
            rd_mux = cnt[i*DATA_W +: DATA_W];
         if (hit(addr, AL_B + i))
            rd_mux = alarm_b[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd)
         rdata <= rd_mux;
   end

   assert_autoclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed);
   assert_rdhold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int NBYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              alarm_irq
);
   localparam int TIME_W = NBYTES * DATA_W;

   logic              run, armed, load, ack, fire;
   logic [TIME_W-1:0] cnt, alarm_val, load_val;

   rtc_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata), .rd(bus_rd), .rdata(bus_rdata), .cnt(cnt),
      .fire(fire), .run(run), .armed(armed), .alarm_val(alarm_val),
      .load(load), .load_val(load_val), .ack(ack)
   );

   rtc_counter #(.TIME_W(TIME_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(sec_tick),
      .load(load), .load_val(load_val), .cnt(cnt)
   );

   rtc_alarm #(.TIME_W(TIME_W)) u_alm (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .alarm_val(alarm_val),
      .armed(armed), .ack(ack), .fire(fire), .irq(alarm_irq)
   );

   assert_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !alarm_irq);
endmodule

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       alarm_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sec_rtc dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
   );

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;
   localparam int NV = 43;
   // {op, addr, data, expected, requirement number}
   localparam logic [25:0] VEC [NV] = '{
      {OP_RD, 4'd0,  8'h00, 8'h00, 4'd1},   // R1 control
      {OP_RD, 4'd1,  8'h00, 8'h00, 4'd1},   // R1 alarm control
      {OP_RD, 4'd6,  8'h00, 8'h00, 4'd1},   // R1 count byte 0
      {OP_RD, 4'd9,  8'h00, 8'h00, 4'd1},   // R1 count byte 3
      {OP_TK, 4'd0,  8'h00, 8'h00, 4'd2},   // R2 tick while stopped
      {OP_RD, 4'd6,  8'h00, 8'h00, 4'd2},
      {OP_WR, 4'd2,  8'h00, 8'h00, 4'd4},   // R4 staged load sequence
      {OP_WR, 4'd3,  8'h34, 8'h00, 4'd4},
      {OP_WR, 4'd4,  8'h12, 8'h00, 4'd4},
      {OP_WR, 4'd5,  8'hAB, 8'h00, 4'd4},
      {OP_RD, 4'd6,  8'h00, 8'h00, 4'd4},
      {OP_RD, 4'd9,  8'h00, 8'h00, 4'd4},   // R4 upper not yet visible
      {OP_RD, 4'd3,  8'h00, 8'h34, 4'd4},   // R4 stage read-back
      {OP_WR, 4'd2,  8'h56, 8'h00, 4'd4},
      {OP_RD, 4'd6,  8'h00, 8'h56, 4'd6},   // R6 byte order
      {OP_RD, 4'd7,  8'h00, 8'h34, 4'd6},
      {OP_RD, 4'd8,  8'h00, 8'h12, 4'd6},
      {OP_RD, 4'd9,  8'h00, 8'hAB, 4'd6},
      {OP_WR, 4'd0,  8'h80, 8'h00, 4'd2},   // R2 start
      {OP_RD, 4'd0,  8'h00, 8'h80, 4'd2},
      {OP_TK, 4'd0,  8'h00, 8'h00, 4'd2},
      {OP_RD, 4'd6,  8'h00, 8'h57, 4'd2},
      {OP_WR, 4'd10, 8'h59, 8'h00, 4'd7},   // R7 alarm bytes
      {OP_WR, 4'd11, 8'h34, 8'h00, 4'd7},
      {OP_WR, 4'd12, 8'h12, 8'h00, 4'd7},
      {OP_WR, 4'd13, 8'hAB, 8'h00, 4'd7},
      {OP_RD, 4'd10, 8'h00, 8'h59, 4'd7},
      {OP_RD, 4'd13, 8'h00, 8'hAB, 4'd7},
      {OP_WR, 4'd1,  8'h02, 8'h00, 4'd8},   // R8 arm
      {OP_RD, 4'd1,  8'h00, 8'h02, 4'd8},
      {OP_IRQ, 4'd0, 8'h00, 8'h00, 4'd8},
      {OP_TK, 4'd0,  8'h00, 8'h00, 4'd8},
      {OP_IRQ, 4'd0, 8'h00, 8'h00, 4'd8},
      {OP_TK, 4'd0,  8'h00, 8'h00, 4'd8},
      {OP_IRQ, 4'd0, 8'h00, 8'h01, 4'd8},   // R8 fires on match
      {OP_RD, 4'd1,  8'h00, 8'h00, 4'd10},  // R10 enable self-cleared
      {OP_WR, 4'd14, 8'h00, 8'h00, 4'd9},   // R9 zero write ignored
      {OP_IRQ, 4'd0, 8'h00, 8'h01, 4'd9},
      {OP_WR, 4'd14, 8'h01, 8'h00, 4'd9},
      {OP_IRQ, 4'd0, 8'h00, 8'h00, 4'd9},
      {OP_RD, 4'd14, 8'h00, 8'h00, 4'd9},
      {OP_RD, 4'd15, 8'h00, 8'h00, 4'd11},  // R11 unmapped
      {OP_RD, 4'd6,  8'h00, 8'h59, 4'd11}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      check(req, bus_rdata, exp);
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic irq_chk(input logic e, input string req);
      @(negedge clk);
      check(req, {7'd0, alarm_irq}, {7'd0, e});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      irq_chk(1'b0, "R1");

      for (int i = 0; i < NV; i++) begin
         automatic logic [1:0] op  = VEC[i][25:24];
         automatic logic [3:0] a   = VEC[i][23:20];
         automatic logic [7:0] d   = VEC[i][19:12];
         automatic logic [7:0] e   = VEC[i][11:4];
         automatic string      req = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
         case (op)
            OP_WR: wr(a, d);
            OP_RD: rd(a, e, req);
            OP_TK: tick();
            default: irq_chk(e[0], req);
         endcase
      end

      // R10: reload counter onto the alarm value without re-arming
      wr(4'd3, 8'h34); wr(4'd4, 8'h12); wr(4'd5, 8'hAB); wr(4'd2, 8'h59);
      irq_chk(1'b0, "R10");
      irq_chk(1'b0, "R10");
      rd(4'd1, 8'h00, "R10");

      // R3: wrap at all-ones
      wr(4'd3, 8'hFF); wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd2, 8'hFF);
      rd(4'd9, 8'hFF, "R3");
      tick();
      rd(4'd6, 8'h00, "R3");
      rd(4'd7, 8'h00, "R3");
      rd(4'd8, 8'h00, "R3");
      rd(4'd9, 8'h00, "R3");

      // R6: carry visible between two low-byte reads
      wr(4'd3, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h00); wr(4'd2, 8'hFF);
      rd(4'd6, 8'hFF, "R6");
      tick();
      rd(4'd6, 8'h00, "R6");
      rd(4'd7, 8'h01, "R6");

      // R5: load and tick in the same cycle, load wins
      @(negedge clk);
      bus_addr = 4'd2; bus_wdata = 8'h10; bus_wr = 1'b1; sec_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; sec_tick = 1'b0;
      rd(4'd6, 8'h10, "R5");
      rd(4'd7, 8'h00, "R5");

      // R2: stop again, tick ignored
      wr(4'd0, 8'h00);
      tick();
      rd(4'd6, 8'h10, "R2");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule